// File: doc/BRIEF.md
# Dual-Sided Inter-Processor Messaging Unit

This block joins two processors, called side A and side B, through a shared set of message registers. Each side has its own 32-bit register port and its own interrupt line. There are four channels in each direction. A side posts a word by writing one of its transmit registers. The word then appears in the matching receive register on the other side. The receiving side collects the word by reading that register, and the read hands the channel back to the sender.

Every channel has a handshake with two flags. A transmit-empty flag on the sending side shows that a new word may be posted. A receive-full flag on the receiving side shows that a word is waiting. Each side has a control register that holds per-channel enable bits for these two flags. The side's single interrupt line is the OR of all enabled flags. Both sides use the same map: transmit words at 0x00..0x0C, receive words at 0x10..0x1C, status at 0x20 and control at 0x24. Addresses are word aligned, and bits 1:0 of the address are not decoded.

Top module: `ipc_msg_unit`

## Requirements
- R1: After reset, both status words read 0x00F00000 (every transmit-empty flag set, every receive-full flag clear), both control words read 0, and both interrupt lines are low.
- R2: A write to transmit offset 4*n on one side, while that side's transmit-empty flag n is set, has three effects. From the next cycle, the peer's receive offset 0x10+4*n returns the word. The peer's receive-full flag n is set. The writer's transmit-empty flag n is clear.
- R3: A read of receive offset 0x10+4*n returns the waiting word in the same cycle. At the clock edge that ends the read, the reader's receive-full flag n clears and the peer's transmit-empty flag n sets.
- R4: A write to a transmit register whose empty flag is clear is ignored. The word already waiting is kept and delivered unchanged.
- R5: Status bits use reversed channel order. Transmit-empty for channel n is bit 20+(3-n) and receive-full for channel n is bit 24+(3-n). All other status bits read 0.
- R6: The control word at 0x24 stores only bits 20+(3-n) (transmit interrupt enable n) and 24+(3-n) (receive interrupt enable n). Other bits read 0. Each side's control word is independent of the other side's.
- R7: A side's interrupt output is high exactly while some status flag and its matching control bit are both set. Writing 0 to the control word drops the line.
- R8: Writes to the status offset or to receive offsets change no flag and no stored word.
- R9: Reads of transmit offsets, of any offset above 0x24, or with read enable low return 0.
- R10: The two directions of a channel are independent. Both sides may post on the same channel in the same cycle, and each side then receives the other's word.
- R11: A read of a receive register whose full flag is clear changes no flag on either side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_addr | input | 6 | Side A byte address |
| a_wr_en | input | 1 | Side A write strobe |
| a_rd_en | input | 1 | Side A read strobe |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, valid in the cycle of the read |
| a_irq | output | 1 | Side A interrupt |
| b_addr | input | 6 | Side B byte address |
| b_wr_en | input | 1 | Side B write strobe |
| b_rd_en | input | 1 | Side B read strobe |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, valid in the cycle of the read |
| b_irq | output | 1 | Side B interrupt |

## Verification
Single posts on one channel at a time, and on channels 0 and 3 together, are compared against the expected status words. These cases tell a correct reversed bit order apart from a straight one, and tell a one-channel update apart from one that spills into another channel. A second post into a full channel, a read of an empty receive register, and writes aimed at status and receive offsets separate "ignored" from "overwritten" and from "flag toggled". Posting on the same channel from both sides in the same cycle shows whether the two directions are really separate. Interrupt checks with single enable bits follow one flag through set, clear and re-set, and confirm that the line tracks only the enabled event.

// File: rtl/ipc_msg_pkg.sv
package ipc_msg_pkg;

  localparam int WORD_W   = 32;
  localparam int SLOT_CNT = 4;   // status/control field slots per flag kind
  localparam int TE_BASE  = 20;  // lowest transmit-empty / tx enable bit
  localparam int RF_BASE  = 24;  // lowest receive-full / rx enable bit

  // bit position of a channel inside the transmit-empty field (reversed order)
  function automatic int te_pos(input int ch);
    return TE_BASE + (SLOT_CNT - 1 - ch);
  endfunction

  // bit position of a channel inside the receive-full field (reversed order)
  function automatic int rf_pos(input int ch);
    return RF_BASE + (SLOT_CNT - 1 - ch);
  endfunction

  // assemble a status word from per-channel flag vectors
  function automatic logic [WORD_W-1:0] pack_flags(input logic [SLOT_CNT-1:0] te,
                                                   input logic [SLOT_CNT-1:0] rf);
    logic [WORD_W-1:0] w;
    w = '0;
    for (int s = 0; s < SLOT_CNT; s++) begin
      w[te_pos(s)] = te[s];
      w[rf_pos(s)] = rf[s];
    end
    return w;
  endfunction

  // writable bits of the control word for a given channel count
  function automatic logic [WORD_W-1:0] ctrl_mask(input int num_ch);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int s = 0; s < SLOT_CNT; s++) begin
      if (s < num_ch) begin
        m[te_pos(s)] = 1'b1;
        m[rf_pos(s)] = 1'b1;
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/ipc_msg_lane.sv
// One channel in one direction: a word buffer plus its full flag.
// The sender sees empty = ~full; the receiver sees full.
module ipc_msg_lane
  import ipc_msg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_wr,
  input  logic              rx_rd,
  input  logic [WORD_W-1:0] wdata,
  output logic              full,
  output logic [WORD_W-1:0] data
);

  logic accept_w;  // sender write that is taken
  logic drain_w;   // receiver read that frees the lane

  assign accept_w = tx_wr & ~full;
  assign drain_w  = rx_rd & full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      if (drain_w)  full <= 1'b0;
      if (accept_w) begin
        full <= 1'b1;
        data <= wdata;
      end
    end
  end

  a_r2_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && !full) |=> (full && data == $past(wdata)));

  a_r4_full_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && full && !rx_rd) |=> (full && $stable(data)));

  a_r3_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && full) |=> !full);

  a_r11_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && !full && !tx_wr) |=> (!full && $stable(data)));

endmodule

// File: rtl/ipc_msg_port.sv
// Register view of one side: address decode, control word, status, interrupt.
module ipc_msg_port
  import ipc_msg_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ADDR_W-1:0]              addr,
  input  logic                           wr_en,
  input  logic                           rd_en,
  input  logic [WORD_W-1:0]              wdata,
  input  logic [NUM_CH-1:0]              tx_full,
  input  logic [NUM_CH-1:0]              rx_full,
  input  logic [NUM_CH-1:0][WORD_W-1:0]  rx_data,
  output logic [NUM_CH-1:0]              tx_wr,
  output logic [NUM_CH-1:0]              rx_rd,
  output logic [WORD_W-1:0]              rdata,
  output logic                           irq
);

  localparam int IDX_W    = ADDR_W - 2;
  localparam int TX_IDX0  = 0;
  localparam int RX_IDX0  = NUM_CH;
  localparam int STAT_IDX = 2 * NUM_CH;
  localparam int CTRL_IDX = 2 * NUM_CH + 1;
  localparam logic [WORD_W-1:0] CTRL_MASK = ctrl_mask(NUM_CH);

  logic [IDX_W-1:0]    word_idx;
  logic [1:0]          unused_lsb;
  logic                hit_ctrl;
  logic                hit_stat;
  logic [NUM_CH-1:0]   hit_tx;
  logic [NUM_CH-1:0]   hit_rx;
  logic [SLOT_CNT-1:0] te_pad;
  logic [SLOT_CNT-1:0] rf_pad;
  logic [WORD_W-1:0]   status_w;
  logic [WORD_W-1:0]   ctrl_q;
  logic                ctrl_load;

  assign word_idx   = addr[ADDR_W-1:2];
  assign unused_lsb = addr[1:0];
  assign hit_ctrl   = (word_idx == IDX_W'(CTRL_IDX));
  assign hit_stat   = (word_idx == IDX_W'(STAT_IDX));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_dec
    assign hit_tx[n] = (word_idx == IDX_W'(TX_IDX0 + n));
    assign hit_rx[n] = (word_idx == IDX_W'(RX_IDX0 + n));
    assign tx_wr[n]  = wr_en & hit_tx[n];
    assign rx_rd[n]  = rd_en & hit_rx[n];
  end

  always_comb begin
    te_pad = '0;
    rf_pad = '0;
    te_pad[NUM_CH-1:0] = ~tx_full;
    rf_pad[NUM_CH-1:0] = rx_full;
  end

  assign status_w  = pack_flags(te_pad, rf_pad);
  assign ctrl_load = wr_en & hit_ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (ctrl_load) ctrl_q <= wdata & CTRL_MASK;
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (hit_stat) rdata = status_w;
      if (hit_ctrl) rdata = ctrl_q;
      for (int n = 0; n < NUM_CH; n++) begin
        if (hit_rx[n]) rdata = rx_data[n];
      end
    end
  end

  assign irq = |(status_w & ctrl_q);

  a_r6_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_load |=> (ctrl_q == ($past(wdata) & CTRL_MASK)));

  a_r6_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_load |=> $stable(ctrl_q));

  a_r7_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q == '0) |-> !irq);

endmodule

// File: rtl/ipc_msg_unit.sv
// Two mirrored register views joined by one lane per channel and direction.
module ipc_msg_unit
  import ipc_msg_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_wr_en,
  input  logic              a_rd_en,
  input  logic [WORD_W-1:0] a_wdata,
  output logic [WORD_W-1:0] a_rdata,
  output logic              a_irq,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_wr_en,
  input  logic              b_rd_en,
  input  logic [WORD_W-1:0] b_wdata,
  output logic [WORD_W-1:0] b_rdata,
  output logic              b_irq
);

  logic [NUM_CH-1:0]             a_tx_wr, a_rx_rd, b_tx_wr, b_rx_rd;
  logic [NUM_CH-1:0]             ab_full, ba_full;
  logic [NUM_CH-1:0][WORD_W-1:0] ab_data, ba_data;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    ipc_msg_lane u_ab (
      .clk   (clk),
      .rst_n (rst_n),
      .tx_wr (a_tx_wr[n]),
      .rx_rd (b_rx_rd[n]),
      .wdata (a_wdata),
      .full  (ab_full[n]),
      .data  (ab_data[n])
    );
    ipc_msg_lane u_ba (
      .clk   (clk),
      .rst_n (rst_n),
      .tx_wr (b_tx_wr[n]),
      .rx_rd (a_rx_rd[n]),
      .wdata (b_wdata),
      .full  (ba_full[n]),
      .data  (ba_data[n])
    );
  end

  ipc_msg_port #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_side_a (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (a_addr),
    .wr_en   (a_wr_en),
    .rd_en   (a_rd_en),
    .wdata   (a_wdata),
    .tx_full (ab_full),
    .rx_full (ba_full),
    .rx_data (ba_data),
    .tx_wr   (a_tx_wr),
    .rx_rd   (a_rx_rd),
    .rdata   (a_rdata),
    .irq     (a_irq)
  );

  ipc_msg_port #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_side_b (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (b_addr),
    .wr_en   (b_wr_en),
    .rd_en   (b_rd_en),
    .wdata   (b_wdata),
    .tx_full (ba_full),
    .rx_full (ab_full),
    .rx_data (ab_data),
    .tx_wr   (b_tx_wr),
    .rx_rd   (b_rx_rd),
    .rdata   (b_rdata),
    .irq     (b_irq)
  );

  // R10: a post from A on channel n leaves the B-to-A lane of channel n untouched
  a_r10_dir_indep: assert property (@(posedge clk) disable iff (!rst_n)
    (|a_tx_wr && !b_wr_en && !a_rd_en) |=> $stable(ba_full));

endmodule

// File: tb/ipc_msg_unit_bench.sv
`timescale 1ns/1ps
module ipc_msg_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  a_addr = '0, b_addr = '0;
  logic        a_wr_en = 1'b0, a_rd_en = 1'b0, b_wr_en = 1'b0, b_rd_en = 1'b0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic [31:0] a_rdata, b_rdata;
  logic        a_irq, b_irq;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  ipc_msg_unit u_ipc_msg_unit (
    .clk(clk), .rst_n(rst_n),
    .a_addr(a_addr), .a_wr_en(a_wr_en), .a_rd_en(a_rd_en), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_irq(a_irq),
    .b_addr(b_addr), .b_wr_en(b_wr_en), .b_rd_en(b_rd_en), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_irq(b_irq)
  );

  localparam bit SA = 1'b0;
  localparam bit SB = 1'b1;
  localparam logic [5:0] STAT = 6'h20;
  localparam logic [5:0] CTRL = 6'h24;

  // expected status: bit 27 holds rf ch0 down to bit 24 = rf ch3, then te the same way
  function automatic logic [31:0] exp_st(input logic [3:0] te, input logic [3:0] rf);
    return {4'h0, rf[0], rf[1], rf[2], rf[3], te[0], te[1], te[2], te[3], 20'h0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input bit side, input logic [5:0] ad, input logic [31:0] d);
    @(negedge clk);
    if (side == SA) begin a_addr = ad; a_wdata = d; a_wr_en = 1'b1; end
    else            begin b_addr = ad; b_wdata = d; b_wr_en = 1'b1; end
    @(negedge clk);
    a_wr_en = 1'b0;
    b_wr_en = 1'b0;
  endtask

  task automatic wr_both(input logic [5:0] ad, input logic [31:0] da, input logic [31:0] db);
    @(negedge clk);
    a_addr = ad; a_wdata = da; a_wr_en = 1'b1;
    b_addr = ad; b_wdata = db; b_wr_en = 1'b1;
    @(negedge clk);
    a_wr_en = 1'b0;
    b_wr_en = 1'b0;
  endtask

  task automatic rd(input bit side, input logic [5:0] ad, output logic [31:0] v);
    @(negedge clk);
    if (side == SA) begin a_addr = ad; a_rd_en = 1'b1; end
    else            begin b_addr = ad; b_rd_en = 1'b1; end
    #1;
    v = (side == SA) ? a_rdata : b_rdata;
    @(negedge clk);
    a_rd_en = 1'b0;
    b_rd_en = 1'b0;
  endtask

  task automatic chk_rd(input string req, input bit side, input logic [5:0] ad,
                        input logic [31:0] exp);
    logic [31:0] v;
    rd(side, ad, v);
    check(req, v, exp);
  endtask

  task automatic chk_irq(input string req, input bit side, input logic exp);
    #1;
    check(req, {31'h0, (side == SA) ? a_irq : b_irq}, {31'h0, exp});
  endtask

  task automatic t_reset;
    check("R1 a_rdata idle", a_rdata, 32'h0);
    chk_rd("R1 status A", SA, STAT, 32'h00F0_0000);
    chk_rd("R1 status B", SB, STAT, 32'h00F0_0000);
    chk_rd("R1 ctrl A", SA, CTRL, 32'h0);
    chk_rd("R1 ctrl B", SB, CTRL, 32'h0);
    chk_irq("R1 irq A", SA, 1'b0);
    chk_irq("R1 irq B", SB, 1'b0);
  endtask

  task automatic t_send_basic;
    wr(SA, 6'h04, 32'hCAFE_0001);
    chk_rd("R2 writer te1 cleared", SA, STAT, exp_st(4'b1101, 4'b0000));
    chk_rd("R2 peer rf1 set", SB, STAT, exp_st(4'b1111, 4'b0010));
    chk_rd("R3 peer reads word", SB, 6'h14, 32'hCAFE_0001);
    chk_rd("R3 reader rf1 cleared", SB, STAT, exp_st(4'b1111, 4'b0000));
    chk_rd("R3 writer te1 restored", SA, STAT, exp_st(4'b1111, 4'b0000));
  endtask

  task automatic t_order;
    wr(SA, 6'h00, 32'h0000_00A0);
    wr(SA, 6'h0C, 32'h0000_00A3);
    chk_rd("R5 rf ch0/ch3 bits 27/24", SB, STAT, 32'h09F0_0000);
    chk_rd("R5 te ch0/ch3 bits 23/20", SA, STAT, 32'h0060_0000);
    chk_rd("R5 ch3 word", SB, 6'h1C, 32'h0000_00A3);
    chk_rd("R5 ch0 word", SB, 6'h10, 32'h0000_00A0);
    chk_rd("R5 all drained", SA, STAT, 32'h00F0_0000);
  endtask

  task automatic t_full_ignore;
    wr(SA, 6'h08, 32'h1111_2222);
    wr(SA, 6'h08, 32'h3333_4444);
    chk_rd("R4 first word kept", SB, 6'h18, 32'h1111_2222);
    chk_rd("R4 channel freed", SA, STAT, 32'h00F0_0000);
  endtask

  task automatic t_empty_read;
    chk_rd("R11 empty read data", SB, 6'h18, 32'h1111_2222);
    chk_rd("R11 reader flags unchanged", SB, STAT, 32'h00F0_0000);
    chk_rd("R11 peer flags unchanged", SA, STAT, 32'h00F0_0000);
  endtask

  task automatic t_ignored_writes;
    wr(SA, 6'h00, 32'h5A5A_0000);
    wr(SB, STAT, 32'h0000_0000);
    wr(SB, 6'h10, 32'hDEAD_BEEF);
    wr(SA, STAT, 32'hFFFF_FFFF);
    chk_rd("R8 receiver status unchanged", SB, STAT, exp_st(4'b1111, 4'b0001));
    chk_rd("R8 sender status unchanged", SA, STAT, exp_st(4'b1110, 4'b0000));
    chk_rd("R8 stored word unchanged", SB, 6'h10, 32'h5A5A_0000);
  endtask

  task automatic t_ctrl;
    wr(SA, CTRL, 32'hFFFF_FFFF);
    chk_rd("R6 ctrl masked", SA, CTRL, 32'h0FF0_0000);
    chk_rd("R6 other side ctrl", SB, CTRL, 32'h0);
    chk_irq("R7 all te enabled", SA, 1'b1);
    chk_irq("R7 peer quiet", SB, 1'b0);
    wr(SA, CTRL, 32'h0);
    chk_irq("R7 ctrl zero drops irq", SA, 1'b0);
  endtask

  task automatic t_irq;
    wr(SA, CTRL, 32'h0040_0000);   // tx enable ch1 = bit 22
    wr(SB, CTRL, 32'h0400_0000);   // rx enable ch1 = bit 26
    chk_irq("R7 te1 enabled", SA, 1'b1);
    chk_irq("R7 rf1 empty", SB, 1'b0);
    wr(SA, 6'h04, 32'h0000_0777);
    chk_irq("R7 te1 cleared", SA, 1'b0);
    chk_irq("R7 rf1 set", SB, 1'b1);
    chk_rd("R3 irq path word", SB, 6'h14, 32'h0000_0777);
    chk_irq("R7 rf1 cleared", SB, 1'b0);
    chk_irq("R7 te1 back", SA, 1'b1);
    wr(SA, CTRL, 32'h0);
    wr(SB, CTRL, 32'h0);
    chk_irq("R7 cleared A", SA, 1'b0);
  endtask

  task automatic t_unmapped;
    chk_rd("R9 offset 0x28", SA, 6'h28, 32'h0);
    chk_rd("R9 offset 0x3C", SB, 6'h3C, 32'h0);
    chk_rd("R9 tx offset", SA, 6'h00, 32'h0);
    #1;
    check("R9 rd_en low", b_rdata, 32'h0);
  endtask

  task automatic t_reverse;
    wr(SB, 6'h0C, 32'hB0B0_0003);
    chk_rd("R10 A rf3", SA, STAT, 32'h01F0_0000);
    chk_rd("R10 B te3", SB, STAT, exp_st(4'b0111, 4'b0000));
    chk_rd("R10 A reads", SA, 6'h1C, 32'hB0B0_0003);
    wr_both(6'h04, 32'hAAAA_0001, 32'hBBBB_0001);
    chk_rd("R10 B gets A word", SB, 6'h14, 32'hAAAA_0001);
    chk_rd("R10 A gets B word", SA, 6'h14, 32'hBBBB_0001);
    chk_rd("R10 A idle", SA, STAT, 32'h00F0_0000);
    chk_rd("R10 B idle", SB, STAT, 32'h00F0_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_send_basic();
    t_order();
    t_full_ignore();
    t_empty_read();
    t_ignored_writes();
    chk_rd("R3 drain ch0", SB, 6'h10, 32'h5A5A_0000);
    t_ctrl();
    t_irq();
    t_unmapped();
    t_reverse();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R1 watchdog actual=%0d expected<%0d", 20000, 20000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule